// File: doc/BRIEF.md
# Bridge I/O Routing Decoder

This block sits where processor I/O cycles leave the host side of a bridge. It holds a 16-bit bridge control register and a pair of window registers that give the lowest and highest I/O address owned by the downstream serial-link port. Every I/O request is steered to one of two places: the downstream port or the legacy path. The choice depends on three things: whether the address lies in the window, whether legacy ISA carve-out is on, and whether VGA I/O forwarding is on in its 10-bit or 16-bit alias form. The routed request appears on the matching output one clock after it was presented.

The same control register drives a hot reset on the downstream port for as long as its reset bit is held at one. Completions from the selected target come back through a return stage. The block always uses the fixed master-abort policy. A read that no target claimed is answered with all ones. A write that no target claimed completes normally and its data is dropped.

Top module: `io_route_bridge`

## Requirements
- R1: After a synchronous reset, the control register reads 0000h, the window low register reads FFFFh, the window high register reads 0000h, hot_reset is 0, and dn_valid, leg_valid and rsp_valid are 0.
- R2: Register select reg_sel=0 is the control register, 1 is the window low address, 2 is the window high address, and 3 reads as zero. In the control register only bits 6, 4, 3, 2 and 1 can be written. Bits 15:7, 5 and 0 read 0 whatever was written. reg_rdata returns the selected register one clock after reg_sel is presented.
- R3: hot_reset equals control bit 6 from the clock edge that writes that bit. It is 1 while the bit is 1 and 0 while it is 0.
- R4: With control bit 2 (ISA carve-out) at 0, a request whose address satisfies low <= addr <= high goes downstream. When low > high the window is empty.
- R5: With bit 2 at 1, a request whose address bits 9:8 are not both zero does not go downstream through the window, even when it lies inside the window. It goes to the legacy path instead.
- R6: With control bit 3 (VGA forwarding) at 1 and bit 4 at 0, a request whose address bits 9:0 lie in 3B0h–3BBh or 3C0h–3DFh goes downstream, whatever the window and ISA settings.
- R7: With bits 3 and 4 both at 1, only addresses with bits 15:10 equal to zero and bits 9:0 in those ranges are VGA matches. Their aliases in higher 1 KB blocks follow the window and ISA rules.
- R8: With bit 3 at 0, bit 4 has no effect on routing.
- R9: A request that matches neither VGA nor the window goes to the legacy path. For each request with req_valid high, exactly one of dn_valid and leg_valid is high on the next clock, with fwd_addr, fwd_write and fwd_wdata carrying that request. With no request, both are low.
- R10: One clock after cpl_valid, rsp_valid is high. A read with cpl_claimed=1 returns cpl_rdata. A read with cpl_claimed=0 returns all ones. A write returns zero data, whether or not it was claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 control, 1 window low, 2 window high |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data of the selected register |
| hot_reset | output | 1 | Hot reset driven to the downstream port |
| req_valid | input | 1 | Processor I/O request valid |
| req_write | input | 1 | Request is a write |
| req_addr | input | 16 | Request I/O address |
| req_wdata | input | 32 | Request write data |
| dn_valid | output | 1 | Request forwarded to the downstream port |
| leg_valid | output | 1 | Request forwarded to the legacy path |
| fwd_addr | output | 16 | Forwarded address |
| fwd_write | output | 1 | Forwarded direction |
| fwd_wdata | output | 32 | Forwarded write data |
| cpl_valid | input | 1 | Completion from the selected target |
| cpl_read | input | 1 | Completion belongs to a read |
| cpl_claimed | input | 1 | A target claimed the cycle |
| cpl_rdata | input | 32 | Completion read data |
| rsp_valid | output | 1 | Response to the processor |
| rsp_rdata | output | 32 | Response read data |

## Verification
The sweeps cross every 1 KB boundary of a window that starts and ends in the middle of a block. They do this under all eight settings of the carve-out, VGA and 16-bit decode bits. A design that tested the wrong address bits for the carve-out, or used an off-by-one window compare, would misroute the addresses at the block and window edges. VGA aliases at 3B0h/3BBh/3DFh and at the neighbouring 3AFh/3BCh/3BFh/3E0h are probed in several high blocks. A decoder that ignored the 16-bit setting would forward those aliases, and one that applied it without VGA forwarding on would change routing when it must not. An empty window (low above high), read-only bits written with ones, the hot reset level and unclaimed reads versus writes are also checked. These catch a mask that lets reserved bits through and an abort path that returns stale data.

// File: rtl/io_bridge_pkg.sv
package io_bridge_pkg;
  localparam int CTL_W = 16;
  // Writable control bits: 6 hot reset, 4 vga 16-bit, 3 vga, 2 isa, 1 err fwd
  localparam logic [CTL_W-1:0] CTL_WR_MASK = 16'h005E;
  localparam int BIT_HOTRST = 6;
  localparam int BIT_VGA16  = 4;
  localparam int BIT_VGA    = 3;
  localparam int BIT_ISA    = 2;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic isa;
    logic vga;
    logic vga16;
  } route_cfg_t;
endpackage

// File: rtl/io_bridge_regs.sv
module io_bridge_regs
  import io_bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wen,
  input  logic [CTL_W-1:0]  reg_wdata,
  output logic [CTL_W-1:0]  reg_rdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [ADDR_W-1:0] low_q,
  output logic [ADDR_W-1:0] high_q
);
  logic [CTL_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      low_q  <= '1;
      high_q <= '0;
    end else if (reg_wen) begin
      case (reg_sel_e'(reg_sel))
        SEL_CTL:  ctl_q  <= reg_wdata & CTL_WR_MASK;
        SEL_LOW:  low_q  <= reg_wdata[ADDR_W-1:0];
        SEL_HIGH: high_q <= reg_wdata[ADDR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(reg_sel))
      SEL_CTL:  rd_mux = ctl_q;
      SEL_LOW:  rd_mux = CTL_W'(low_q);
      SEL_HIGH: rd_mux = CTL_W'(high_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/io_route_decode.sv
module io_route_decode
  import io_bridge_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ALIAS_W = 10,
  parameter logic [ALIAS_W-1:0] VGA_A_LO = 10'h3B0,
  parameter logic [ALIAS_W-1:0] VGA_A_HI = 10'h3BB,
  parameter logic [ALIAS_W-1:0] VGA_B_LO = 10'h3C0,
  parameter logic [ALIAS_W-1:0] VGA_B_HI = 10'h3DF
) (
  input  logic              clk,
  input  logic              rst,
  input  route_cfg_t        cfg,
  input  logic [ADDR_W-1:0] low_q,
  input  logic [ADDR_W-1:0] high_q,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              dn_valid,
  output logic              leg_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic [DATA_W-1:0] fwd_wdata
);
  localparam int CARVE_HI = ALIAS_W - 1;
  localparam int CARVE_LO = ALIAS_W - 2;

  logic [ALIAS_W-1:0] alias_bits;
  logic               alias_in_vga;
  logic               upper_zero;
  logic               vga_hit;
  logic               win_hit;
  logic               isa_cut;
  logic               to_dn;

  assign alias_bits   = req_addr[ALIAS_W-1:0];
  assign alias_in_vga = ((alias_bits >= VGA_A_LO) && (alias_bits <= VGA_A_HI)) ||
                        ((alias_bits >= VGA_B_LO) && (alias_bits <= VGA_B_HI));

  generate
    if (ADDR_W > ALIAS_W) begin : g_upper
      assign upper_zero = (req_addr[ADDR_W-1:ALIAS_W] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    vga_hit = cfg.vga && alias_in_vga && (!cfg.vga16 || upper_zero);
    win_hit = (low_q <= high_q) && (req_addr >= low_q) && (req_addr <= high_q);
    isa_cut = cfg.isa && (req_addr[CARVE_HI:CARVE_LO] != 2'b00);
    to_dn   = vga_hit || (win_hit && !isa_cut);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid  <= 1'b0;
      leg_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_write <= 1'b0;
      fwd_wdata <= '0;
    end else begin
      dn_valid  <= req_valid && to_dn;
      leg_valid <= req_valid && !to_dn;
      if (req_valid) begin
        fwd_addr  <= req_addr;
        fwd_write <= req_write;
        fwd_wdata <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/io_cpl_return.sv
module io_cpl_return #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpl_valid,
  input  logic              cpl_read,
  input  logic              cpl_claimed,
  input  logic [DATA_W-1:0] cpl_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] ret_data;

  always_comb begin
    if (!cpl_read)        ret_data = '0;
    else if (cpl_claimed) ret_data = cpl_rdata;
    else                  ret_data = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cpl_valid;
      if (cpl_valid) rsp_rdata <= ret_data;
    end
  end
endmodule

// File: rtl/io_route_bridge.sv
module io_route_bridge
  import io_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wen,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              hot_reset,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              dn_valid,
  output logic              leg_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              fwd_write,
  output logic [DATA_W-1:0] fwd_wdata,
  input  logic              cpl_valid,
  input  logic              cpl_read,
  input  logic              cpl_claimed,
  input  logic [DATA_W-1:0] cpl_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [CTL_W-1:0]  ctl_q;
  logic [ADDR_W-1:0] low_q;
  logic [ADDR_W-1:0] high_q;
  route_cfg_t        cfg;

  io_bridge_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctl_q(ctl_q), .low_q(low_q), .high_q(high_q)
  );

  assign hot_reset = ctl_q[BIT_HOTRST];
  assign cfg.isa   = ctl_q[BIT_ISA];
  assign cfg.vga   = ctl_q[BIT_VGA];
  assign cfg.vga16 = ctl_q[BIT_VGA16];

  io_route_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .cfg(cfg), .low_q(low_q), .high_q(high_q),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .dn_valid(dn_valid), .leg_valid(leg_valid),
    .fwd_addr(fwd_addr), .fwd_write(fwd_write), .fwd_wdata(fwd_wdata)
  );

  io_cpl_return #(.DATA_W(DATA_W)) u_cpl (
    .clk(clk), .rst(rst), .cpl_valid(cpl_valid), .cpl_read(cpl_read),
    .cpl_claimed(cpl_claimed), .cpl_rdata(cpl_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/io_route_bridge_chk.sv
module io_route_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_sel,
  input logic              reg_wen,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic              hot_reset,
  input logic              req_valid,
  input logic              dn_valid,
  input logic              leg_valid,
  input logic [15:0]       ctl_q,
  input logic [ADDR_W-1:0] low_q,
  input logic [ADDR_W-1:0] high_q,
  input logic              cpl_valid,
  input logic              cpl_read,
  input logic              cpl_claimed,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata
);
  assert_ro_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_sel == 2'd0) && !$past(rst)) |-> ((reg_rdata & 16'hFFA1) == 16'h0000));

  assert_hot_reset_level_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_wen && reg_sel == 2'd0) && !$past(rst)) |-> (hot_reset == $past(reg_wdata[6])));

  assert_empty_window_legacy_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid && !ctl_q[3] && (low_q > high_q)) && !$past(rst)) |-> (leg_valid && !dn_valid));

  assert_one_route_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && !$past(rst)) |-> ($countones({dn_valid, leg_valid}) == 1));

  assert_no_route_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (!dn_valid && !leg_valid));

  assert_abort_all_ones_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(cpl_valid && cpl_read && !cpl_claimed) && !$past(rst)) |-> (rsp_valid && (rsp_rdata == '1)));

  assert_write_no_data_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(cpl_valid && !cpl_read) && !$past(rst)) |-> (rsp_valid && (rsp_rdata == '0)));
endmodule

bind io_route_bridge io_route_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .hot_reset(hot_reset), .req_valid(req_valid),
  .dn_valid(dn_valid), .leg_valid(leg_valid), .ctl_q(ctl_q), .low_q(low_q),
  .high_q(high_q), .cpl_valid(cpl_valid), .cpl_read(cpl_read),
  .cpl_claimed(cpl_claimed), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
);

// File: tb/io_route_bridge_test.sv
module io_route_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wen = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        hot_reset;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [31:0] req_wdata = 32'h0;
  logic        dn_valid, leg_valid, fwd_write;
  logic [15:0] fwd_addr;
  logic [31:0] fwd_wdata;
  logic        cpl_valid = 1'b0, cpl_read = 1'b0, cpl_claimed = 1'b0;
  logic [31:0] cpl_rdata = 32'h0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  io_route_bridge uut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hot_reset(hot_reset), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .dn_valid(dn_valid), .leg_valid(leg_valid), .fwd_addr(fwd_addr),
    .fwd_write(fwd_write), .fwd_wdata(fwd_wdata), .cpl_valid(cpl_valid),
    .cpl_read(cpl_read), .cpl_claimed(cpl_claimed), .cpl_rdata(cpl_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd_reg(input string req, input logic [1:0] sel, input logic [15:0] exp);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    check(req, {16'h0, reg_rdata}, {16'h0, exp});
  endtask

  // Expected route from the requirements: 1 = downstream
  function automatic bit exp_dn(input logic [15:0] a, input bit isa, input bit vga,
                                input bit v16, input logic [15:0] lo, input logic [15:0] hi);
    logic [9:0] al;
    bit in_vga, vhit, win, cut;
    al = a[9:0];
    in_vga = (al >= 10'h3B0 && al <= 10'h3BB) || (al >= 10'h3C0 && al <= 10'h3DF);
    vhit = vga && in_vga && (!v16 || a[15:10] == 6'd0);
    win = (lo <= hi) && (a >= lo) && (a <= hi);
    cut = isa && (a[9:8] != 2'b00);
    return vhit || (win && !cut);
  endfunction

  function automatic string tag_for(input logic [15:0] a, input bit isa, input bit vga, input bit v16);
    bit in_vga;
    in_vga = (a[9:0] >= 10'h3B0 && a[9:0] <= 10'h3BB) || (a[9:0] >= 10'h3C0 && a[9:0] <= 10'h3DF);
    if (vga && in_vga) return v16 ? "R7" : "R6";
    if (!vga && v16)   return "R8";
    if (isa)           return "R5";
    return "R4";
  endfunction

  task automatic do_req(input logic [15:0] a, input bit isa, input bit vga, input bit v16,
                        input logic [15:0] lo, input logic [15:0] hi);
    bit e;
    e = exp_dn(a, isa, vga, v16, lo, hi);
    req_valid = 1'b1; req_addr = a; req_write = a[0]; req_wdata = {16'hA5A5, a};
    @(negedge clk);
    req_valid = 1'b0;
    check(tag_for(a, isa, vga, v16), {30'd0, dn_valid, leg_valid}, {30'd0, e, !e});
  endtask

  initial begin
    logic [15:0] lo, hi;
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", {29'd0, hot_reset, dn_valid, leg_valid}, 32'd0);
    check("R1", {31'd0, rsp_valid}, 32'd0);
    rd_reg("R1", 2'd0, 16'h0000);
    rd_reg("R1", 2'd1, 16'hFFFF);
    rd_reg("R1", 2'd2, 16'h0000);

    // R2 read-only bits ignore writes
    wr_reg(2'd0, 16'hFFFF);
    rd_reg("R2", 2'd0, 16'h005E);
    check("R3", {31'd0, hot_reset}, 32'd1);
    wr_reg(2'd0, 16'hFFA1);
    rd_reg("R2", 2'd0, 16'h0000);
    check("R3", {31'd0, hot_reset}, 32'd0);
    wr_reg(2'd3, 16'h1234);
    rd_reg("R2", 2'd3, 16'h0000);
    rd_reg("R2", 2'd0, 16'h0000);

    // R3 hot reset timing: high from the write edge
    @(negedge clk);
    reg_sel = 2'd0; reg_wdata = 16'h0040; reg_wen = 1'b1;
    @(posedge clk); #1;
    reg_wen = 1'b0;
    check("R3", {31'd0, hot_reset}, 32'd1);
    wr_reg(2'd0, 16'h0000);
    check("R3", {31'd0, hot_reset}, 32'd0);

    // R4 empty window (reset window low > high), all legacy
    @(negedge clk);
    for (int k = 0; k < 16; k++) do_req(16'(k * 16'h1111), 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0000);

    // Window crossing 1 KB blocks, all eight config combinations
    lo = 16'h0123; hi = 16'h0B9A;
    wr_reg(2'd1, lo);
    wr_reg(2'd2, hi);
    rd_reg("R2", 2'd1, lo);
    rd_reg("R2", 2'd2, hi);
    for (int c = 0; c < 8; c++) begin
      bit isa, vga, v16;
      isa = c[0]; vga = c[1]; v16 = c[2];
      wr_reg(2'd0, {11'd0, v16, vga, isa, 2'b10});
      @(negedge clk);
      for (int a = 0; a < 16'h1000; a++) do_req(16'(a), isa, vga, v16, lo, hi);
      // VGA aliases in higher blocks
      for (int b = 1; b < 64; b = b * 3 + 1) begin
        for (int o = 16'h3A8; o < 16'h3E4; o++)
          do_req(16'(b * 1024 + o), isa, vga, v16, lo, hi);
      end
    end

    // R9 forwarded fields
    wr_reg(2'd0, 16'h0000);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0456; req_write = 1'b1; req_wdata = 32'hDEADBEEF;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", {31'd0, dn_valid}, 32'd1);
    check("R9", {16'd0, fwd_addr}, 32'h0456);
    check("R9", {31'd0, fwd_write}, 32'd1);
    check("R9", fwd_wdata, 32'hDEADBEEF);
    @(negedge clk);
    check("R9", {30'd0, dn_valid, leg_valid}, 32'd0);
    req_valid = 1'b1; req_addr = 16'hF000; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", {30'd0, dn_valid, leg_valid}, 32'd1);

    // R10 completions
    cpl_valid = 1'b1; cpl_read = 1'b1; cpl_claimed = 1'b1; cpl_rdata = 32'h13572468;
    @(negedge clk);
    cpl_valid = 1'b0;
    check("R10", {31'd0, rsp_valid}, 32'd1);
    check("R10", rsp_rdata, 32'h13572468);
    cpl_valid = 1'b1; cpl_read = 1'b1; cpl_claimed = 1'b0;
    @(negedge clk);
    cpl_valid = 1'b0;
    check("R10", rsp_rdata, 32'hFFFFFFFF);
    cpl_valid = 1'b1; cpl_read = 1'b0; cpl_claimed = 1'b0;
    @(negedge clk);
    cpl_valid = 1'b0;
    check("R10", {31'd0, rsp_valid}, 32'd1);
    check("R10", rsp_rdata, 32'h0);
    @(negedge clk);
    check("R10", {31'd0, rsp_valid}, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule